// File: doc/BRIEF.md
# SPI Frame-Length Error Detector

This block watches the two active-low chip selects and the single-cycle SCLK rising-edge pulses of a serial port. It decides at the end of each transaction whether the number of clocks received fits the decoded select mode. A transaction starts when either select falls while both were high. It ends when both selects are high again. While one select is low, the legal counts are 16, 24, 32 and so on. If both selects are low at the same moment at any point in the transaction, the minimum becomes 32 (legal counts 32, 40, ...). That larger minimum holds until the transaction ends, even if one select rises earlier.

The block keeps one global error flag. Any frame on either select can set or clear it. Power-up and wake-from-sleep events also set it. The flag is read at the start of the next transaction. While a select is low and no clock has arrived yet, the block raises a lead-window indication. It also provides the flag ORed with the serial input, so the shifter can drive that value before the first clock and a set flag ripples down a daisy chain. A legal, non-empty frame produces a one-cycle frame-valid pulse that tells the data path to latch the received command. All inputs are assumed already synchronized to `clk`.

Top module: `spi_frame_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `err_flag` is 1 and `frame_ok` is 0.
- R2: A transaction in which only one select was ever low, with N SCLK rises where N = 16 + 8k, is legal. In the cycle after both selects are seen high, `frame_ok` is 1 and `err_flag` is 0.
- R3: A transaction with a non-zero, non-legal count sets `err_flag` to 1 in the cycle after its end and gives no `frame_ok`. While both selects stay high and no event arrives, `err_flag` does not change.
- R4: If both selects are low together at any sampled cycle of a transaction, only counts of 32 + 8k are legal. For example, 16 or 24 clocks under both selects set the flag, and 32 or 40 clocks clear it.
- R5: The 32 minimum persists after one select rises while the other is still low. The transaction is judged with that minimum when both are high.
- R6: A transaction with zero SCLK rises leaves `err_flag` unchanged and gives no `frame_ok`.
- R7: A `por_evt` or `wake_evt` pulse sets `err_flag` to 1 in the next cycle. This takes priority over a legal frame ending in the same cycle.
- R8: `lead_win` is 1 exactly while at least one select is low and no SCLK rise has been counted in the current transaction.
- R9: `lead_bit` equals `err_flag` OR `sdi`.
- R10: `frame_ok` is a single-cycle pulse, issued once per legal non-empty transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-on |
| cs_a_n | input | 1 | First chip select, active low, synchronized |
| cs_b_n | input | 1 | Second chip select, active low, synchronized |
| sclk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| sdi | input | 1 | Serial data input level |
| por_evt | input | 1 | Pulse: supply came out of power-on reset |
| wake_evt | input | 1 | Pulse: left sleep into the global-off state |
| frame_ok | output | 1 | One-cycle pulse after a legal non-empty transaction |
| err_flag | output | 1 | Global transmission-error flag |
| lead_win | output | 1 | Select low and no clock counted yet |
| lead_bit | output | 1 | Error flag ORed with `sdi`, the early serial output value |

## Verification
The hardest case is the wide-mode latch surviving a partial release. One select opens the frame and clocks arrive. The second select then falls, the first rises while the second remains low, and more clocks follow. The stimulus builds exactly this staggered sequence with 24 total clocks, which must fail, and 32, which must pass. A single-select reading of 24 would wrongly accept the first case. A second hard case is a power-up event landing on the same cycle as the end of a legal frame. There the pulse must still appear while the flag ends up set.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        VERD_IDLE  = 2'd0,
        VERD_EMPTY = 2'd1,
        VERD_PASS  = 2'd2,
        VERD_FAIL  = 2'd3
    } verdict_e;

    // Judge a finished transaction from its saturated count, granule phase
    // and whether both selects were ever low together.
    function automatic verdict_e judge_frame(
        input int unsigned cnt_sat,
        input bit          phase_zero,
        input bit          wide,
        input int unsigned min_single,
        input int unsigned min_dual
    );
        int unsigned floor_v;
        floor_v = wide ? min_dual : min_single;
        if (cnt_sat == 0)
            return VERD_EMPTY;
        else if (cnt_sat >= floor_v && phase_zero)
            return VERD_PASS;
        else
            return VERD_FAIL;
    endfunction

endpackage

// File: rtl/sfc_counter.sv
module sfc_counter
    import sfc_pkg::*;
#(
    parameter int unsigned MIN_SINGLE = 16,
    parameter int unsigned MIN_DUAL   = 32,
    parameter int unsigned GRAN       = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_a_n,
    input  logic     cs_b_n,
    input  logic     sclk_rise,
    output logic     lead_win,
    output verdict_e verdict
);
    localparam int unsigned SW = $clog2(MIN_DUAL + 1);
    localparam int unsigned PW = (GRAN > 1) ? $clog2(GRAN) : 1;
    localparam logic [SW-1:0] SAT_TOP  = SW'(MIN_DUAL);
    localparam logic [PW-1:0] PH_LAST  = PW'(GRAN - 1);

    logic          active, both_low, end_evt;
    logic          act_q, wide_q;
    logic [SW-1:0] sat_q;
    logic [PW-1:0] phase_q;

    always_comb begin
        active   = !cs_a_n || !cs_b_n;
        both_low = !cs_a_n && !cs_b_n;
        end_evt  = act_q && !active;
        lead_win = active && (sat_q == '0);
        verdict  = end_evt ? judge_frame(int'(sat_q), phase_q == '0, wide_q,
                                         MIN_SINGLE, MIN_DUAL)
                           : VERD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            wide_q  <= 1'b0;
            sat_q   <= '0;
            phase_q <= '0;
        end else begin
            act_q <= active;
            if (!active) begin
                wide_q  <= 1'b0;
                sat_q   <= '0;
                phase_q <= '0;
            end else begin
                if (both_low)
                    wide_q <= 1'b1;
                if (sclk_rise) begin
                    if (sat_q != SAT_TOP)
                        sat_q <= sat_q + SW'(1);
                    phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sfc_flag.sv
module sfc_flag
    import sfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_e verdict,
    input  logic     por_evt,
    input  logic     wake_evt,
    output logic     err_flag,
    output logic     frame_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b1;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= (verdict == VERD_PASS);
            if (por_evt || wake_evt)
                err_flag <= 1'b1;
            else if (verdict == VERD_PASS)
                err_flag <= 1'b0;
            else if (verdict == VERD_FAIL)
                err_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker
    import sfc_pkg::*;
#(
    parameter int unsigned MIN_SINGLE = 16,
    parameter int unsigned MIN_DUAL   = 32,
    parameter int unsigned GRAN       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_a_n,
    input  logic cs_b_n,
    input  logic sclk_rise,
    input  logic sdi,
    input  logic por_evt,
    input  logic wake_evt,
    output logic frame_ok,
    output logic err_flag,
    output logic lead_win,
    output logic lead_bit
);
    verdict_e verdict;

    sfc_counter #(
        .MIN_SINGLE (MIN_SINGLE),
        .MIN_DUAL   (MIN_DUAL),
        .GRAN       (GRAN)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .cs_a_n    (cs_a_n),
        .cs_b_n    (cs_b_n),
        .sclk_rise (sclk_rise),
        .lead_win  (lead_win),
        .verdict   (verdict)
    );

    sfc_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .por_evt  (por_evt),
        .wake_evt (wake_evt),
        .err_flag (err_flag),
        .frame_ok (frame_ok)
    );

    assign lead_bit = err_flag | sdi;

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
    input logic clk,
    input logic rst,
    input logic cs_a_n,
    input logic cs_b_n,
    input logic sdi,
    input logic por_evt,
    input logic wake_evt,
    input logic frame_ok,
    input logic err_flag,
    input logic lead_win,
    input logic lead_bit
);
    // R7
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $past(por_evt || wake_evt) |-> err_flag);

    // R10
    ok_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> !frame_ok);

    // R2
    ok_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && !$past(por_evt || wake_evt)) |-> !err_flag);

    // R8
    lead_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        lead_win |-> (!cs_a_n || !cs_b_n));

    // R3
    idle_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_a_n && cs_b_n) && $past(cs_a_n && cs_b_n, 2)
         && !$past(por_evt || wake_evt)) |-> $stable(err_flag));

    // R9
    lead_bit_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag || sdi) |-> lead_bit);

endmodule

bind spi_frame_checker sfc_checker u_chk (.*);

// File: tb/spi_frame_checker_bench.sv
module spi_frame_checker_bench;
    localparam int CLK_PER  = 10;
    localparam int WDOG_MAX = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_a_n = 1'b1, cs_b_n = 1'b1, sclk_rise = 1'b0, sdi = 1'b0;
    logic por_evt = 1'b0, wake_evt = 1'b0;
    logic frame_ok, err_flag, lead_win, lead_bit;

    int n_chk = 0, n_fail = 0, ok_cnt = 0, cycles = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0;
    bit m_wide = 0, m_prev = 0, m_err = 1, m_ok = 0;

    always #(CLK_PER/2) clk = ~clk;

    spi_frame_checker u_spi_frame_checker (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .sclk_rise(sclk_rise), .sdi(sdi), .por_evt(por_evt),
        .wake_evt(wake_evt), .frame_ok(frame_ok), .err_flag(err_flag),
        .lead_win(lead_win), .lead_bit(lead_bit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, compared every cycle
    always @(posedge clk) begin
        bit act, end_now, legal;
        int floor_v;
        act = !(cs_a_n && cs_b_n);
        if (rst) begin
            m_err = 1; m_ok = 0; m_cnt = 0; m_wide = 0; m_prev = 0;
        end else begin
            end_now = m_prev && !act;
            m_ok = 0;
            legal = 0;
            if (end_now && m_cnt != 0) begin
                floor_v = m_wide ? 32 : 16;
                legal = (m_cnt >= floor_v) && (m_cnt % 8 == 0);
                m_ok = legal;
            end
            if (por_evt || wake_evt) m_err = 1;
            else if (end_now && m_cnt != 0) m_err = !legal;
            if (act) begin
                if (sclk_rise) m_cnt++;
                if (!cs_a_n && !cs_b_n) m_wide = 1;
            end else begin
                m_cnt = 0; m_wide = 0;
            end
            m_prev = act;
        end
        #(CLK_PER/4);
        if (rst) begin
            chk("R1 err_flag in reset", err_flag, 1'b1);
            chk("R1 frame_ok in reset", frame_ok, 1'b0);
        end else begin
            if (frame_ok === 1'b1) ok_cnt++;
            chk("R10 frame_ok vs model", frame_ok, m_ok);
            chk("R3 err_flag vs model", err_flag, m_err);
            chk("R8 lead_win vs model", lead_win,
                !(cs_a_n && cs_b_n) && (m_cnt == 0));
            chk("R9 lead_bit vs model", lead_bit, m_err | sdi);
        end
    end

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sclk_rise = 1'b1; sdi = i[0];
            @(negedge clk) sclk_rise = 1'b0;
        end
    endtask

    // one transaction; result checked against expected flag and pulse count
    task automatic frame(input string req, input bit use_a, input bit use_b,
                         input int n, input bit exp_err, input int exp_ok,
                         input bit por_at_end);
        int ok0;
        ok0 = ok_cnt;
        @(negedge clk) cs_a_n = !use_a; cs_b_n = !use_b;
        @(negedge clk);
        chk("R8 lead_win before first clock", lead_win, 1'b1);
        pulses(n);
        @(negedge clk) cs_a_n = 1'b1; cs_b_n = 1'b1; por_evt = por_at_end; sdi = 1'b0;
        @(negedge clk) por_evt = 1'b0;
        @(negedge clk);
        chk(req, err_flag, exp_err);
        n_chk++;
        if (ok_cnt - ok0 != exp_ok) begin
            n_fail++;
            $display("FAIL %s pulses: got %0d expected %0d", req, ok_cnt - ok0, exp_ok);
        end
    endtask

    // staggered: A opens, B joins, A leaves, B closes
    task automatic staggered(input string req, input int n1, input int n2,
                             input int n3, input bit exp_err);
        @(negedge clk) cs_a_n = 1'b0;
        pulses(n1);
        @(negedge clk) cs_b_n = 1'b0;
        pulses(n2);
        @(negedge clk) cs_a_n = 1'b1;
        pulses(n3);
        @(negedge clk) cs_b_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req, err_flag, exp_err);
    endtask

    task automatic pulse_evt(input bit which);
        @(negedge clk) if (which) wake_evt = 1'b1; else por_evt = 1'b1;
        @(negedge clk) wake_evt = 1'b0; por_evt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 err_flag after reset", err_flag, 1'b1);
        chk("R1 frame_ok after reset", frame_ok, 1'b0);
        frame("R6 empty frame keeps set flag", 1, 0, 0, 1, 0, 0);
        frame("R2 16 clocks on A legal", 1, 0, 16, 0, 1, 0);
        frame("R2 24 clocks on B legal", 0, 1, 24, 0, 1, 0);
        frame("R3 20 clocks illegal", 1, 0, 20, 1, 0, 0);
        frame("R6 empty frame on B keeps set flag", 0, 1, 0, 1, 0, 0);
        frame("R3 8 clocks below minimum", 1, 0, 8, 1, 0, 0);
        frame("R2 32 clocks on A legal", 1, 0, 32, 0, 1, 0);
        frame("R4 16 clocks on both illegal", 1, 1, 16, 1, 0, 0);
        frame("R4 32 clocks on both legal", 1, 1, 32, 0, 1, 0);
        frame("R4 24 clocks on both illegal", 1, 1, 24, 1, 0, 0);
        frame("R4 40 clocks on both legal", 1, 1, 40, 0, 1, 0);
        staggered("R5 staggered 24 clocks illegal", 8, 8, 8, 1);
        staggered("R5 staggered 32 clocks legal", 8, 8, 16, 0);
        frame("R6 empty frame keeps clear flag", 1, 0, 0, 0, 0, 0);
        pulse_evt(0);
        chk("R7 power-up sets flag", err_flag, 1'b1);
        frame("R2 16 clocks after power-up", 1, 0, 16, 0, 1, 0);
        pulse_evt(1);
        chk("R7 wake sets flag", err_flag, 1'b1);
        frame("R2 clear after wake", 0, 1, 16, 0, 1, 0);
        frame("R7 power-up beats legal end", 1, 0, 16, 1, 1, 1);
        @(negedge clk) sdi = 1'b1;
        @(negedge clk);
        chk("R9 lead_bit with sdi high", lead_bit, 1'b1);
        frame("R2 final clear", 1, 0, 24, 0, 1, 0);
        @(negedge clk) sdi = 1'b0;
        @(negedge clk);
        chk("R9 lead_bit both low", lead_bit, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_MAX && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WDOG_MAX);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule